// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block decides which power state a small 8-bit microcontroller core is in (Run, Idle or Power-down) and drives the enables and pin controls that go with each state. Software enters a low-power state by writing a control word that carries an Idle request bit and a Power-down request bit. In Idle the CPU clock stops while the peripheral clock and the oscillator keep running. In Power-down the oscillator is turned off as well. The external bus strobes, the multiplexed ports and the PWM pins are placed in fixed states while the core sleeps.

Idle ends on any enabled interrupt. Power-down ends on hardware reset, or on a qualified external interrupt. An interrupt qualifies only when three things are set: the wake enable bit, that line's interrupt enable, and level-sensitive triggering for that line. A low level on a qualified line restarts the oscillator. The CPU clock comes back only when two conditions hold: a programmable stabilisation count has run out and the line has gone high again.

The reset path also waits for the stabilisation count before the CPU clock returns. It then pulses an SFR-reset strobe for one cycle. An interrupt wake-up never pulses that strobe, so register contents are kept. All outputs are registered.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high, and until the stabilisation count expires after it falls, `cpu_clk_en`=0, `per_clk_en`=0 and `osc_en`=1. `cpu_clk_en` rises on the (L+1)-th rising edge after `rst` is first sampled low, where L is `stab_limit`. `sfr_rst` is 1 in exactly that cycle and 0 in the cycles before and after it.
- R2: In Run, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1, and `strobe_hold`, `pwm_high`, `p0_float`, `p2_addr`, `mode_idle` and `mode_pdown` are all 0.
- R3: A write (`ctl_wr`=1) in Run with `ctl_idle_req`=1 and `ctl_pd_req`=0 enters Idle at that edge. In Idle, `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1 and `mode_idle`=1. A write with both request bits at 0 leaves the block in Run.
- R4: A write in Run with `ctl_pd_req`=1 enters Power-down at that edge, whatever the value of `ctl_idle_req`. In Power-down, `cpu_clk_en`=0, `per_clk_en`=0, `osc_en`=0 and `mode_pdown`=1. `mode_idle` and `mode_pdown` are never 1 together.
- R5: In Idle, the block stays put while `irq_pend`=0. At the first edge that samples `irq_pend`=1 it returns to Run with `mode_idle` cleared, and `sfr_rst` stays 0.
- R6: In Power-down, a low level on `xint_n[j]` starts a wake-up only when `wake_en`, `xint_en[j]` and `xint_level[j]` are all 1 (`xint_level[j]`=1 means level-sensitive). In every other case `osc_en` stays 0 until reset.
- R7: On a qualified wake, `osc_en` rises at the edge that samples the line low, and `mode_pdown` stays 1. Counting that edge as edge 1, with the line first sampled high at edge H+1, `cpu_clk_en` rises at edge max(L+2, H+1). At that point `mode_pdown` clears and `sfr_rst` stays 0.
- R8: In Idle, `strobe_hold`=1 and `strobe_val`=1 (strobes driven high). In Power-down, including the wait for wake-up, `strobe_hold`=1 and `strobe_val`=0. `pwm_high`=1 in both modes.
- R9: In Idle and in Power-down, `p0_float` equals the `ext_exec` value registered at the previous edge. `p2_addr` is 1 only in Idle with `ext_exec`=1.
- R10: `rst` wins over any write or wake event in the same cycle. A reset taken from Power-down, or during the wake-up wait, follows R1, including the `sfr_rst` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_idle_req | input | 1 | Idle request bit of the written word |
| ctl_pd_req | input | 1 | Power-down request bit of the written word |
| wake_en | input | 1 | Allows interrupts to end Power-down |
| xint_en | input | N_XINT | Per-line external interrupt enable |
| xint_level | input | N_XINT | Per-line trigger type, 1 = level-sensitive |
| xint_n | input | N_XINT | External interrupt pins, active low |
| irq_pend | input | 1 | Any enabled interrupt pending (ends Idle) |
| ext_exec | input | 1 | Core is executing from external memory |
| stab_limit | input | CNT_W | Oscillator stabilisation count |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| strobe_hold | output | 1 | Bus strobes forced to `strobe_val` |
| strobe_val | output | 1 | Forced strobe level |
| p0_float | output | 1 | Port 0 released to high impedance |
| p2_addr | output | 1 | Port 2 keeps driving the address |
| pwm_high | output | 1 | PWM outputs forced high |
| sfr_rst | output | 1 | One-cycle register reinitialisation strobe |
| mode_idle | output | 1 | Idle request bit as seen by software |
| mode_pdown | output | 1 | Power-down request bit as seen by software |

## Verification
Two events can fall in the same cycle: a hardware reset together with either a Power-down request write or an in-progress wake-up. The bench raises `rst` in the same cycle as a write that has both request bits set. It also raises `rst` while a wake line is held low during the stabilisation wait. In both cases it expects the reset state at the next edge, and then the full R1 timing with its single `sfr_rst` pulse. Separately, it sweeps the stabilisation count against the length of time the wake line stays low, and judges the exit edge against the maximum rule of R7.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PM_RSTWAIT = 3'd0,
    PM_RUN     = 3'd1,
    PM_IDLE    = 3'd2,
    PM_PDOWN   = 3'd3,
    PM_WAKE    = 3'd4
  } pm_state_t;
endpackage

// File: rtl/pm_wake_detect.sv
module pm_wake_detect #(
  parameter int N_XINT = 2
) (
  input  logic              wake_en,
  input  logic [N_XINT-1:0] xint_en,
  input  logic [N_XINT-1:0] xint_level,
  input  logic [N_XINT-1:0] xint_n,
  output logic              wake_req,
  output logic              pin_low
);
  logic [N_XINT-1:0] lane_ok;

  // A line may end Power-down only if it is enabled and level-sensitive
  for (genvar j = 0; j < N_XINT; j++) begin : g_lane
    assign lane_ok[j] = xint_en[j] & xint_level[j] & ~xint_n[j];
  end

  assign pin_low  = |lane_ok;
  assign wake_req = wake_en & pin_low;
endmodule

// File: rtl/pm_stab_timer.sv
module pm_stab_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (!done)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pm_pin_select.sv
module pm_pin_select
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  pm_state_t st_n,
  input  logic      ext_exec,
  output logic      cpu_clk_en,
  output logic      per_clk_en,
  output logic      osc_en,
  output logic      strobe_hold,
  output logic      strobe_val,
  output logic      p0_float,
  output logic      p2_addr,
  output logic      pwm_high,
  output logic      mode_idle,
  output logic      mode_pdown
);
  // Outputs are decoded from the next state, so they line up with the state register
  always_ff @(posedge clk) begin
    cpu_clk_en  <= 1'b0;
    per_clk_en  <= 1'b0;
    osc_en      <= 1'b1;
    strobe_hold <= 1'b0;
    strobe_val  <= 1'b0;
    p0_float    <= 1'b0;
    p2_addr     <= 1'b0;
    pwm_high    <= 1'b0;
    mode_idle   <= 1'b0;
    mode_pdown  <= 1'b0;
    case (st_n)
      PM_RUN: begin
        cpu_clk_en <= 1'b1;
        per_clk_en <= 1'b1;
      end
      PM_IDLE: begin
        per_clk_en  <= 1'b1;
        strobe_hold <= 1'b1;
        strobe_val  <= 1'b1;
        p0_float    <= ext_exec;
        p2_addr     <= ext_exec;
        pwm_high    <= 1'b1;
        mode_idle   <= 1'b1;
      end
      PM_PDOWN, PM_WAKE: begin
        osc_en      <= (st_n == PM_WAKE);
        strobe_hold <= 1'b1;
        p0_float    <= ext_exec;
        pwm_high    <= 1'b1;
        mode_pdown  <= 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_XINT = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              ctl_idle_req,
  input  logic              ctl_pd_req,
  input  logic              wake_en,
  input  logic [N_XINT-1:0] xint_en,
  input  logic [N_XINT-1:0] xint_level,
  input  logic [N_XINT-1:0] xint_n,
  input  logic              irq_pend,
  input  logic              ext_exec,
  input  logic [CNT_W-1:0]  stab_limit,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              strobe_hold,
  output logic              strobe_val,
  output logic              p0_float,
  output logic              p2_addr,
  output logic              pwm_high,
  output logic              sfr_rst,
  output logic              mode_idle,
  output logic              mode_pdown
);
  pm_state_t st, st_n;
  logic      wake_req, pin_low, tmr_done, tmr_clr;

  pm_wake_detect #(.N_XINT(N_XINT)) u_wake (
    .wake_en   (wake_en),
    .xint_en   (xint_en),
    .xint_level(xint_level),
    .xint_n    (xint_n),
    .wake_req  (wake_req),
    .pin_low   (pin_low)
  );

  // Timer counts only while waiting for the oscillator
  assign tmr_clr = rst | ~((st == PM_WAKE) | (st == PM_RSTWAIT));

  pm_stab_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .clr  (tmr_clr),
    .limit(stab_limit),
    .done (tmr_done)
  );

  always_comb begin
    st_n = st;
    if (rst) begin
      st_n = PM_RSTWAIT;
    end else begin
      case (st)
        PM_RSTWAIT: if (tmr_done) st_n = PM_RUN;
        PM_RUN: begin
          if (ctl_wr && ctl_pd_req)        st_n = PM_PDOWN;
          else if (ctl_wr && ctl_idle_req) st_n = PM_IDLE;
        end
        PM_IDLE:  if (irq_pend) st_n = PM_RUN;
        PM_PDOWN: if (wake_req) st_n = PM_WAKE;
        PM_WAKE:  if (tmr_done && !pin_low) st_n = PM_RUN;
        default:  st_n = PM_RSTWAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    st      <= st_n;
    sfr_rst <= !rst && (st == PM_RSTWAIT) && tmr_done;
  end

  pm_pin_select u_pins (
    .clk        (clk),
    .st_n       (st_n),
    .ext_exec   (ext_exec),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .strobe_hold(strobe_hold),
    .strobe_val (strobe_val),
    .p0_float   (p0_float),
    .p2_addr    (p2_addr),
    .pwm_high   (pwm_high),
    .mode_idle  (mode_idle),
    .mode_pdown (mode_pdown)
  );
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int N_XINT = 2
) (
  input logic clk,
  input logic rst,
  input logic wake_en,
  input logic ext_exec,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic osc_en,
  input logic strobe_hold,
  input logic strobe_val,
  input logic p2_addr,
  input logic pwm_high,
  input logic sfr_rst,
  input logic mode_idle,
  input logic mode_pdown
);
  assert_sfr_single_R1: assert property (@(posedge clk) disable iff (rst)
    sfr_rst |=> !sfr_rst);
  assert_sfr_at_run_R1: assert property (@(posedge clk) disable iff (rst)
    sfr_rst |-> (cpu_clk_en && !$past(cpu_clk_en)));
  assert_clk_needs_osc_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> osc_en);
  assert_idle_clocks_R3: assert property (@(posedge clk) disable iff (rst)
    mode_idle |-> (per_clk_en && !cpu_clk_en && osc_en));
  assert_modes_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mode_idle, mode_pdown}));
  assert_wake_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_pdown && !osc_en && !wake_en) |=> !osc_en);
  assert_no_direct_run_R7: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> !cpu_clk_en);
  assert_pd_pins_R8: assert property (@(posedge clk) disable iff (rst)
    mode_pdown |-> (strobe_hold && !strobe_val && pwm_high));
  assert_p2_idle_R9: assert property (@(posedge clk) disable iff (rst)
    p2_addr |-> (mode_idle && $past(ext_exec)));
  assert_reset_wins_R10: assert property (@(posedge clk)
    rst |=> (!cpu_clk_en && osc_en && !mode_pdown && !mode_idle));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_XINT(N_XINT)) u_chk (.*);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
  localparam int NX = 2;
  localparam int CW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, ctl_wr, ctl_idle_req, ctl_pd_req, wake_en, irq_pend, ext_exec;
  logic [NX-1:0] xint_en, xint_level, xint_n;
  logic [CW-1:0] stab_limit;
  logic cpu_clk_en, per_clk_en, osc_en, strobe_hold, strobe_val, p0_float, p2_addr;
  logic pwm_high, sfr_rst, mode_idle, mode_pdown;

  int checks = 0;
  int errors = 0;

  pwr_mode_ctrl #(.N_XINT(NX), .CNT_W(CW)) u_pwr_mode_ctrl (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Reset with limit lim, return edge count until CPU clock returns; checks R1 pulse
  task automatic reset_run(input int lim, output int edges);
    stab_limit = lim[CW-1:0];
    ctl_wr = 0; irq_pend = 0;
    rst = 1; tick(); tick();
    chk("R1", "cpu_clk_en in reset", cpu_clk_en, 0);
    chk("R1", "osc_en in reset", osc_en, 1);
    rst = 0;
    edges = -1;
    for (int k = 1; k <= 64; k++) begin
      tick();
      if (cpu_clk_en) begin
        edges = k;
        chk("R1", "sfr_rst at run entry", sfr_rst, 1);
        break;
      end
      if (sfr_rst) chk("R1", "early sfr_rst", sfr_rst, 0);
    end
    tick();
    chk("R1", "sfr_rst after pulse", sfr_rst, 0);
  endtask

  task automatic write_ctl(input logic idle_b, input logic pd_b);
    ctl_wr = 1; ctl_idle_req = idle_b; ctl_pd_req = pd_b;
    tick();
    ctl_wr = 0; ctl_idle_req = 0; ctl_pd_req = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int e;
    rst = 1; ctl_wr = 0; ctl_idle_req = 0; ctl_pd_req = 0; wake_en = 0;
    xint_en = '0; xint_level = '0; xint_n = '1; irq_pend = 0; ext_exec = 0;
    stab_limit = 2;
    tick(); tick();
    chk("R1", "per_clk_en in reset", per_clk_en, 0);
    chk("R1", "sfr_rst in reset", sfr_rst, 0);

    // R1: reset exit timing sweep
    for (int lim = 0; lim <= 5; lim++) begin
      reset_run(lim, e);
      chk("R1", $sformatf("run edge lim=%0d", lim), e, lim + 1);
    end

    // R2: run outputs
    chk("R2", "cpu_clk_en", cpu_clk_en, 1);
    chk("R2", "per_clk_en", per_clk_en, 1);
    chk("R2", "osc_en", osc_en, 1);
    chk("R2", "forcing", {strobe_hold, pwm_high, p0_float, p2_addr, mode_idle, mode_pdown}, 0);

    // R3: empty write leaves Run
    write_ctl(0, 0);
    chk("R3", "empty write stays run", cpu_clk_en, 1);

    // R3/R5/R8/R9: Idle entry and exit for both execution sources
    for (int ee = 0; ee < 2; ee++) begin
      ext_exec = ee[0];
      write_ctl(1, 0);
      chk("R3", "idle cpu", cpu_clk_en, 0);
      chk("R3", "idle per/osc/mode", {per_clk_en, osc_en, mode_idle}, 3'b111);
      chk("R8", "idle strobes/pwm", {strobe_hold, strobe_val, pwm_high}, 3'b111);
      chk("R9", "idle p0_float", p0_float, ee);
      chk("R9", "idle p2_addr", p2_addr, ee);
      repeat (3) tick();
      chk("R5", "idle holds w/o irq", mode_idle, 1);
      irq_pend = 1; tick(); irq_pend = 0;
      chk("R5", "idle exit cpu", cpu_clk_en, 1);
      chk("R5", "idle exit mode/sfr", {mode_idle, sfr_rst}, 0);
    end

    // R4/R8/R9: Power-down entry, with and without idle bit
    for (int v = 0; v < 4; v++) begin
      ext_exec = v[0];
      write_ctl(v[1], 1);
      chk("R4", "pd clocks", {cpu_clk_en, per_clk_en, osc_en}, 0);
      chk("R4", "pd modes", {mode_idle, mode_pdown}, 2'b01);
      chk("R8", "pd strobes/pwm", {strobe_hold, strobe_val, pwm_high}, 3'b101);
      chk("R9", "pd p0/p2", {p0_float, p2_addr}, {v[0], 1'b0});
      reset_run(1, e);
      chk("R10", "reset from pd", e, 2);
    end
    ext_exec = 0;

    // R6/R7: wake qualification sweep per line
    for (int ln = 0; ln < NX; ln++) begin
      for (int code = 0; code < 8; code++) begin
        reset_run(1, e);
        write_ctl(0, 1);
        wake_en = code[2];
        xint_en = NX'(code[1]) << ln;
        xint_level = NX'(code[0]) << ln;
        xint_n[ln] = 0;
        tick();
        if (code == 7) begin
          chk("R7", "osc restarts on low", osc_en, 1);
          chk("R7", "still asleep", {cpu_clk_en, mode_pdown}, 2'b01);
          xint_n[ln] = 1;
          e = -1;
          for (int k = 2; k <= 20; k++) begin
            tick();
            if (cpu_clk_en) begin e = k; break; end
          end
          chk("R7", "qualified wake edge", e, 3);
        end else begin
          repeat (3) tick();
          xint_n[ln] = 1;
          tick();
          chk("R6", $sformatf("no wake ln=%0d code=%0d", ln, code), osc_en, 0);
          chk("R6", "still pd", {cpu_clk_en, mode_pdown, sfr_rst}, 3'b010);
        end
        wake_en = 0; xint_en = '0; xint_level = '0;
      end
    end

    // R7: exit edge vs stabilisation count and low time
    for (int lim = 0; lim <= 3; lim++) begin
      for (int h = 1; h <= 5; h++) begin
        reset_run(lim, e);
        wake_en = 1; xint_en = 2'b01; xint_level = 2'b01;
        write_ctl(0, 1);
        xint_n[0] = 0;
        e = -1;
        for (int k = 1; k <= 40; k++) begin
          tick();
          if (k == 1) chk("R7", "osc on at edge 1", osc_en, 1);
          if (k == h) xint_n[0] = 1;
          if (cpu_clk_en) begin e = k; break; end
        end
        chk("R7", $sformatf("exit edge lim=%0d h=%0d", lim, h), e,
            ((lim + 2) > (h + 1)) ? (lim + 2) : (h + 1));
        chk("R7", "exit keeps sfr/mode", {sfr_rst, mode_pdown}, 0);
        wake_en = 0; xint_en = '0; xint_level = '0;
      end
    end

    // R10: reset in the same cycle as a Power-down write
    reset_run(2, e);
    rst = 1; ctl_wr = 1; ctl_pd_req = 1; ctl_idle_req = 1;
    tick();
    ctl_wr = 0; ctl_pd_req = 0; ctl_idle_req = 0;
    chk("R10", "reset beats write", {cpu_clk_en, osc_en, mode_pdown, mode_idle}, 4'b0100);
    reset_run(2, e);
    chk("R10", "reset timing after clash", e, 3);

    // R10: reset during the wake-up wait
    wake_en = 1; xint_en = 2'b10; xint_level = 2'b10; stab_limit = 6;
    write_ctl(0, 1);
    xint_n[1] = 0; tick();
    chk("R10", "wake wait entered", {osc_en, mode_pdown}, 2'b11);
    rst = 1; tick();
    chk("R10", "reset in wake wait", {cpu_clk_en, osc_en, mode_pdown}, 3'b010);
    xint_n[1] = 1; wake_en = 0; xint_en = '0; xint_level = '0;
    reset_run(3, e);
    chk("R10", "reset timing after wake clash", e, 4);

    summary();
    $finish;
  end
endmodule